// File: doc/BRIEF.md
# Oscillator Lock Acquisition Sequencer

This block steers a tunable reference oscillator from power-up to phase lock on a once-per-second timing pulse. Each second a measurement unit presents a signed phase-error sample, in nanoseconds, together with a strobe. It also presents a flag that reports the end of the current DAC gain calibration. The sequencer walks through a fixed series of stages. It calibrates the coarse DAC gain and then the fine DAC gain. It then trims frequency from the change in phase between successive pulses and realigns the local phase count with a jam-sync strobe. After that it trims the phase rate, realigns again, and finally holds on a 20-sample running average of the phase error.

In every tuning stage the 16-bit tuning word gets a proportional correction with a gain set per stage. The word clamps at its end codes. If the averaged phase error in the hold stage grows past its limit, the machine drops back to the phase-rate stage and reacquires from there. The `locked` output is high only in the hold stage.

Top module: `lock_acq_seq`

## Requirements
- R1: While the reset input is low, and for the two clocks after it rises, the stage is 0, the tuning word is 0x8000, and jam_sync and locked are 0.
- R2: The stage codes are: 0 coarse-gain calibration, 1 fine-gain calibration, 2 frequency tune, 3 first jam, 4 phase-rate tune, 5 second jam, 6 hold. In stages 0 and 1 a sample with cal_done high advances the stage by one. A sample with cal_done low leaves the stage as it is. The tuning word never changes in these two stages.
- R3: In a cycle without smp_valid, neither the stage nor the tuning word changes, whatever phase_err and cal_done hold.
- R4: In stage 2 the first sample is only recorded. Each later sample gives delta = sample minus previous sample, and the tuning word becomes word − 4·delta. If |delta| < 50, the stage moves to 3.
- R5: In stage 3 or 5 the next sample raises jam_sync for exactly one clock, leaves the tuning word unchanged, and advances the stage to 4 or 6 respectively.
- R6: Stage 4 behaves like stage 2 with a gain of 2 instead of 4. It moves to stage 5 when |delta| < 50. The first sample after entering stage 4 is only recorded.
- R7: In stage 6 every sample e sets the tuning word to word − e. locked is 1 exactly while the stage is 6. The averaging history is empty on each entry to stage 6.
- R8: Once stage 6 holds 20 samples, if the absolute sum of the latest 20 exceeds 20 (mean above 1 ns), the stage returns to 4 and locked falls. A sum of exactly 20 keeps the lock.
- R9: The tuning word clamps at 0 and 65535 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | One-clock strobe marking a new per-second sample |
| phase_err | input | 16 | Signed phase error of the sample in ns |
| cal_done | input | 1 | Current gain calibration finished (read on the strobe) |
| tune_word | output | 16 | Oscillator tuning word |
| jam_sync | output | 1 | One-clock strobe to realign the local phase count |
| acq_stage | output | 3 | Current acquisition stage code |
| locked | output | 1 | High while in the averaged hold stage |

## Verification
Every output is registered. A sample strobed in one cycle therefore shows its stage, tuning word, jam_sync and locked result right after the next rising edge, with no added latency. The bench drives the strobe on a falling edge and compares all four outputs with its model at the following falling edge. One falling edge later it checks that jam_sync has dropped. Idle cycles follow with random data and cal_done, and after those the bench checks again that nothing has moved.

// File: rtl/lock_acq_pkg.sv
package lock_acq_pkg;

  typedef enum logic [2:0] {
    ST_CAL_HI = 3'd0,
    ST_CAL_LO = 3'd1,
    ST_FREQ   = 3'd2,
    ST_JAM_A  = 3'd3,
    ST_RATE   = 3'd4,
    ST_JAM_B  = 3'd5,
    ST_HOLD   = 3'd6
  } acq_stage_e;

endpackage

// File: rtl/lock_avg_window.sv
module lock_avg_window #(
  parameter int W     = 16,
  parameter int DEPTH = 20,
  localparam int SUM_W = W + $clog2(DEPTH) + 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    push,
  input  logic signed [W-1:0]     din,
  output logic signed [SUM_W-1:0] sum_nxt,
  output logic                    full_nxt
);

  logic signed [W-1:0]     hist_q [DEPTH];
  logic signed [SUM_W-1:0] sum_q;
  logic [CNT_W-1:0]        cnt_q;
  logic                    full_q;

  assign full_q = (cnt_q == CNT_W'(DEPTH));

  always_comb begin
    sum_nxt = sum_q + SUM_W'(din);
    if (full_q) sum_nxt = sum_nxt - SUM_W'(hist_q[DEPTH-1]);
    full_nxt = full_q || (cnt_q == CNT_W'(DEPTH - 1));
  end

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_tap
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    hist_q[gi] <= '0;
        else if (clr)  hist_q[gi] <= '0;
        else if (push) begin
          if (gi == 0) hist_q[gi] <= din;
          else         hist_q[gi] <= hist_q[(gi == 0) ? 0 : gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      sum_q <= '0;
      cnt_q <= '0;
    end else if (push) begin
      sum_q <= sum_nxt;
      if (!full_q) cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH)); // R8

endmodule

// File: rtl/lock_tune_sat.sv
module lock_tune_sat #(
  parameter int TW = 16
) (
  input  logic [TW-1:0]      cur,
  input  logic signed [31:0] corr,
  output logic [TW-1:0]      nxt
);

  localparam logic signed [33:0] MAXV = (34'sd1 <<< TW) - 34'sd1;

  logic signed [33:0] t;

  always_comb begin
    t = $signed(34'(cur)) - 34'(corr);
    if (t < 34'sd0)     nxt = '0;
    else if (t > MAXV)  nxt = '1;
    else                nxt = t[TW-1:0];
  end

endmodule

// File: rtl/lock_acq_seq.sv
module lock_acq_seq
  import lock_acq_pkg::*;
#(
  parameter int PHASE_W   = 16,
  parameter int TUNE_W    = 16,
  parameter int AVG_N     = 20,
  parameter int FREQ_LIM  = 50,
  parameter int RATE_LIM  = 50,
  parameter int HOLD_LIM  = 1,
  parameter int FREQ_GAIN = 4,
  parameter int RATE_GAIN = 2,
  parameter int HOLD_GAIN = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_valid,
  input  logic [PHASE_W-1:0] phase_err,
  input  logic               cal_done,
  output logic [TUNE_W-1:0]  tune_word,
  output logic               jam_sync,
  output logic [2:0]         acq_stage,
  output logic               locked
);

  localparam int SUM_W = PHASE_W + $clog2(AVG_N) + 1;
  localparam logic signed [31:0] KF  = 32'(FREQ_GAIN);
  localparam logic signed [31:0] KR  = 32'(RATE_GAIN);
  localparam logic signed [31:0] KH  = 32'(HOLD_GAIN);
  localparam logic signed [31:0] AVG_MAX = 32'(HOLD_LIM * AVG_N);
  localparam logic [TUNE_W-1:0]  MID = TUNE_W'(1) << (TUNE_W - 1);

  // reset release synchroniser
  logic [1:0] rst_pipe;
  logic       rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rs_n = rst_pipe[1];

  acq_stage_e          stage_q, stage_d;
  logic [TUNE_W-1:0]   tune_q, tune_d, tune_sat;
  logic                jam_q, jam_d, lock_q, lock_d;
  logic                pv_q, pv_d;
  logic [PHASE_W-1:0]  prev_q, prev_d;

  logic signed [PHASE_W:0]  delta;
  logic signed [31:0]       d32, e32, corr, s32;
  logic signed [SUM_W-1:0]  avg_sum;
  logic                     avg_full, avg_push, avg_clr;
  logic                     freq_ok, rate_ok, avg_over;

  assign delta = $signed({phase_err[PHASE_W-1], phase_err})
               - $signed({prev_q[PHASE_W-1], prev_q});
  assign d32   = 32'(delta);
  assign e32   = 32'($signed(phase_err));
  assign s32   = 32'(avg_sum);

  assign freq_ok  = (d32 < 32'(FREQ_LIM)) && (d32 > -32'(FREQ_LIM));
  assign rate_ok  = (d32 < 32'(RATE_LIM)) && (d32 > -32'(RATE_LIM));
  assign avg_over = (s32 > AVG_MAX) || (s32 < -AVG_MAX);

  assign avg_push = smp_valid && (stage_q == ST_HOLD);
  assign avg_clr  = (stage_q != ST_HOLD);

  lock_avg_window #(.W(PHASE_W), .DEPTH(AVG_N)) u_avg (
    .clk      (clk),
    .rst_n    (rs_n),
    .clr      (avg_clr),
    .push     (avg_push),
    .din      ($signed(phase_err)),
    .sum_nxt  (avg_sum),
    .full_nxt (avg_full)
  );

  // correction selected by stage
  always_comb begin
    case (stage_q)
      ST_FREQ: corr = d32 * KF;
      ST_RATE: corr = d32 * KR;
      ST_HOLD: corr = e32 * KH;
      default: corr = '0;
    endcase
  end

  lock_tune_sat #(.TW(TUNE_W)) u_sat (
    .cur  (tune_q),
    .corr (corr),
    .nxt  (tune_sat)
  );

  // next-state logic
  always_comb begin
    stage_d = stage_q;
    tune_d  = tune_q;
    jam_d   = 1'b0;
    pv_d    = 1'b0;
    prev_d  = prev_q;
    case (stage_q)
      ST_CAL_HI: if (smp_valid && cal_done) stage_d = ST_CAL_LO;
      ST_CAL_LO: if (smp_valid && cal_done) stage_d = ST_FREQ;
      ST_FREQ, ST_RATE: begin
        pv_d = pv_q;
        if (smp_valid) begin
          prev_d = phase_err;
          pv_d   = 1'b1;
          if (pv_q) begin
            tune_d = tune_sat;
            if (stage_q == ST_FREQ && freq_ok) stage_d = ST_JAM_A;
            if (stage_q == ST_RATE && rate_ok) stage_d = ST_JAM_B;
          end
        end
      end
      ST_JAM_A: if (smp_valid) begin jam_d = 1'b1; stage_d = ST_RATE; end
      ST_JAM_B: if (smp_valid) begin jam_d = 1'b1; stage_d = ST_HOLD; end
      ST_HOLD: if (smp_valid) begin
        tune_d = tune_sat;
        if (avg_full && avg_over) stage_d = ST_RATE;
      end
      default: stage_d = ST_CAL_HI;
    endcase
    lock_d = (stage_d == ST_HOLD);
  end

  // state registers
  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      stage_q <= ST_CAL_HI;
      tune_q  <= MID;
      jam_q   <= 1'b0;
      lock_q  <= 1'b0;
      pv_q    <= 1'b0;
      prev_q  <= '0;
    end else begin
      stage_q <= stage_d;
      tune_q  <= tune_d;
      jam_q   <= jam_d;
      lock_q  <= lock_d;
      pv_q    <= pv_d;
      prev_q  <= prev_d;
    end
  end

  assign tune_word = tune_q;
  assign jam_sync  = jam_q;
  assign acq_stage = stage_q;
  assign locked    = lock_q;

  AST_CAL_TUNE_FROZEN: assert property (@(posedge clk) disable iff (!rs_n)
    (acq_stage == 3'd0 || acq_stage == 3'd1) |=> $stable(tune_word)); // R2
  AST_IDLE_NO_MOVE: assert property (@(posedge clk) disable iff (!rs_n)
    !smp_valid |=> ($stable(acq_stage) && $stable(tune_word))); // R3
  AST_JAM_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rs_n)
    jam_sync |-> $past(smp_valid)); // R5
  AST_JAM_TUNE_KEPT: assert property (@(posedge clk) disable iff (!rs_n)
    jam_sync |-> $stable(tune_word)); // R5
  AST_JAM_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rs_n)
    jam_sync |=> !jam_sync); // R5
  AST_LOCK_IN_HOLD: assert property (@(posedge clk) disable iff (!rs_n)
    locked |-> (acq_stage == 3'd6)); // R7
  AST_HOLD_EXIT: assert property (@(posedge clk) disable iff (!rs_n)
    (acq_stage == 3'd6) |=> (acq_stage == 3'd6 || acq_stage == 3'd4)); // R8
  AST_STAGE_LEGAL: assert property (@(posedge clk) disable iff (!rs_n)
    acq_stage != 3'd7); // R2

endmodule

// File: tb/lock_acq_seq_tb.sv
module lock_acq_seq_tb;

  logic        clk;
  logic        rst_n;
  logic        smp_valid;
  logic [15:0] phase_err;
  logic        cal_done;
  logic [15:0] tune_word;
  logic        jam_sync;
  logic [2:0]  acq_stage;
  logic        locked;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // bench model state
  int m_stage, m_tune, m_prev, m_jam;
  bit m_pv;
  int m_hist[$];
  int last_pe;

  lock_acq_seq u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .phase_err (phase_err),
    .cal_done  (cal_done),
    .tune_word (tune_word),
    .jam_sync  (jam_sync),
    .acq_stage (acq_stage),
    .locked    (locked)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int clamp_tw(int v);
    if (v < 0)     return 0;
    if (v > 65535) return 65535;
    return v;
  endfunction

  function automatic int abs_i(int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic model_step(int pe, bit cal);
    int d, s;
    m_jam = 0;
    case (m_stage)
      0, 1: if (cal) m_stage++;
      2, 4: begin
        if (m_pv) begin
          d = pe - m_prev;
          m_tune = clamp_tw(m_tune - ((m_stage == 2) ? 4 : 2) * d);
          if (abs_i(d) < 50) m_stage++;
        end
        m_prev = pe;
        m_pv = 1;
        if (m_stage != 2 && m_stage != 4) m_pv = 0;
      end
      3, 5: begin
        m_jam = 1;
        m_stage++;
        m_pv = 0;
        m_hist.delete();
      end
      6: begin
        m_tune = clamp_tw(m_tune - pe);
        m_hist.push_back(pe);
        if (m_hist.size() > 20) void'(m_hist.pop_front());
        s = 0;
        foreach (m_hist[i]) s += m_hist[i];
        if (m_hist.size() == 20 && abs_i(s) > 20) begin
          m_stage = 4;
          m_pv = 0;
        end
      end
      default: ;
    endcase
  endtask

  task automatic check_all(string tag);
    check_eq({tag, " stage"}, int'(acq_stage), m_stage);
    check_eq({tag, " tune"},  int'(tune_word), m_tune);
    check_eq({tag, " jam"},   int'(jam_sync),  m_jam);
    check_eq({"R7 locked"},   int'(locked),    (m_stage == 6) ? 1 : 0);
  endtask

  // one strobed sample, result checked one edge later, then idle cycles
  task automatic do_sample(int pe, bit cal, string tag);
    int idle;
    phase_err = 16'(pe);
    cal_done  = cal;
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    model_step(pe, cal);
    check_all(tag);
    idle = int'($urandom_range(2, 1));
    for (int k = 0; k < idle; k++) begin
      phase_err = 16'($urandom);
      cal_done  = 1'($urandom);
      @(negedge clk);
      m_jam = 0;
      check_all("R3 idle");
    end
    if (m_jam != 0) check_eq("R5 jam pulse", int'(jam_sync), 0);
  endtask

  function automatic int gen_pe();
    int r;
    case (m_stage)
      2, 4: begin
        if ($urandom_range(3) == 0) r = last_pe + int'($urandom_range(80)) - 40;
        else                        r = last_pe + int'($urandom_range(600)) - 300;
        if (abs_i(r) > 20000) r = 0;
      end
      6: begin
        if ($urandom_range(19) == 0) r = int'($urandom_range(400)) - 200;
        else                         r = int'($urandom_range(2)) - 1;
      end
      default: r = int'($urandom_range(200)) - 100;
    endcase
    return r;
  endfunction

  task automatic drive_to_hold();
    for (int k = 0; k < 60 && m_stage != 6; k++)
      do_sample(0, 1'b1, "R4 R6 approach");
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; smp_valid = 1'b0; phase_err = '0; cal_done = 1'b0;
    m_stage = 0; m_tune = 32768; m_prev = 0; m_jam = 0; m_pv = 0; last_pe = 0;
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after release");
    @(negedge clk);

    // R2 calibration stages
    do_sample(123, 1'b0, "R2 hold cal0");
    do_sample(-7, 1'b1, "R2 adv cal0");
    do_sample(55, 1'b0, "R2 hold cal1");
    do_sample(9, 1'b1, "R2 adv cal1");

    // R9 saturation in the frequency stage, R4 first sample recorded
    do_sample(30000, 1'b0, "R4 first");
    do_sample(-30000, 1'b0, "R9 high");
    check_eq("R9 clamp high", int'(tune_word), 65535);
    do_sample(30000, 1'b0, "R9 low");
    check_eq("R9 clamp low", int'(tune_word), 0);
    last_pe = 0;

    // constrained random sweep
    for (int n = 0; n < 500; n++) begin
      int pe;
      pe = gen_pe();
      last_pe = pe;
      do_sample(pe, 1'($urandom), "R4 R5 R6 R7 R8 random");
    end

    // directed averaging boundary
    if (m_stage < 2) begin
      do_sample(0, 1'b1, "R2 finish");
      do_sample(0, 1'b1, "R2 finish");
    end
    drive_to_hold();
    check_eq("R7 reached hold", int'(acq_stage), 6);
    for (int k = 0; k < 20; k++) do_sample(1, 1'b0, "R8 at limit");
    check_eq("R8 sum 20 keeps lock", int'(locked), 1);
    do_sample(2, 1'b0, "R8 over limit");
    check_eq("R8 fall back stage", int'(acq_stage), 4);
    check_eq("R8 fall back lock", int'(locked), 0);

    // R6 first sample after fallback only recorded
    do_sample(500, 1'b0, "R6 record");
    do_sample(520, 1'b0, "R6 pass");
    check_eq("R6 to jam", int'(acq_stage), 5);
    do_sample(0, 1'b0, "R5 jam b");
    check_eq("R5 jam stage", int'(acq_stage), 6);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule